// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block takes a requested output frequency in kHz and finds settings for a clock synthesizer that runs from a fixed reference crystal. The settings are a post-divider exponent `m`, a feedback count `P`, a reference count `Q` and a VCO band index. The block clamps the request. It then sweeps every usable `m` together with every `Q` in the allowed range. For each pair it derives `P` by rounding, and it keeps the candidate whose `P/Q` best matches the wanted VCO-to-reference ratio. Among equally good ratios it prefers the candidate whose VCO lies nearer the middle of its band. The winning settings come out packed into one 21-bit programming word.

All arithmetic is fixed-point integer, and ratio and deviation comparisons use cross-multiplication. After a search, the block decodes the word it found into the frequency that word really produces. The same decode path can be started alone on any supplied word. One `start` pulse launches an operation, `busy` is high while it runs, and `done` pulses once when the outputs are ready.

Top module: `pll_search_engine`

## Requirements
- R1: A request below 7000 kHz is treated as 7000 kHz, and a request above 120000 kHz is treated as 120000 kHz. A clamped request produces exactly the same word as the limit it was clamped to.
- R2: The chosen exponent `m` (word bits 9:7) makes the clamped request times 2^m lie between 50000 and 120000 kHz inclusive.
- R3: The chosen `Q` (word bits 6:0 plus 2) lies in 14..71, and the chosen `P` (word bits 16:10 plus 3) lies in 4..130.
- R4: For each candidate (m, Q), `P` is the nearest integer to Q·V/REF, with halves rounded up. V is the VCO frequency and REF is 28636.36 kHz, held as 1876712489 in units of 2^-16 kHz. The result minimises |P/Q − V/REF| over all candidates. Among equal minima, the candidate with the smallest |V − band midpoint|/V wins. Remaining ties go to the earliest candidate, with m ascending first and Q ascending within each m.
- R5: The band index (word bits 20:17) is the largest i in 0..13 with V ≥ edge[i]. The edges in kHz for i = 0..14 are 50000, 51000, 53200, 58500, 60700, 64400, 66800, 73500, 75600, 80900, 83200, 91500, 100000, 120000, 120000. The band midpoint is (edge[i] + edge[i+1]) / 2.
- R6: The word is packed as {index[3:0], (P−3)[6:0], m[2:0], (Q−2)[6:0]}, with the index in the most significant bits.
- R7: A decode operation (`op_decode` = 1) sets `freq_khz` to floor(1876712489·P / (Q·2^(m+16))), where P = bits 16:10 + 3, Q = bits 6:0 + 2 and m = bits 9:7 of `word_in`. Bits 20:17 have no effect on the result, and `no_match` is 0.
- R8: When a search completes, `freq_khz` equals the decode of `word_out` as defined in R7.
- R9: `busy` rises on the cycle after an accepted `start` and stays high until `done`. `done` is a single-cycle pulse with `busy` low. A `start` seen while `busy` is high is ignored. The outputs hold from `done` until the next accepted operation.
- R10: After reset, `busy`, `done`, `no_match`, `word_out` and `freq_khz` are all zero.
- R11: If no candidate is valid, `done` comes with `no_match` = 1, `word_out` = 0 and `freq_khz` = 0. With the default limits every clamped request has a valid candidate, so `no_match` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation when idle |
| op_decode | input | 1 | 1: decode `word_in`; 0: search for `req_khz` |
| req_khz | input | 20 | Requested frequency in kHz |
| word_in | input | 21 | Programming word to decode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| word_out | output | 21 | Packed programming word found (or echoed on decode) |
| freq_khz | output | 24 | Achieved frequency in kHz |
| no_match | output | 1 | No valid candidate existed |

## Verification
The bench targets requests on both sides of the clamp limits. A design that compared against the wrong bound or clamped after shifting would return a different word for 1000 kHz than for 7000 kHz. It also targets requests where two exponents both place the VCO inside the window, such as 50000 and 57272 kHz. A design that swept `m` in the wrong order, or that replaced the best candidate on any tie, would pick a different `P/Q` there. Decode words that share fields except the band index catch a decoder that lets bits 20:17 leak into the quotient. A `start` pulse issued mid-search catches a design that restarts on it and so returns the word for the second request.

// File: rtl/pll_search_pkg.sv
`timescale 1ns/1ps
package pll_search_pkg;
  localparam int FRAC   = 16;   // fractional bits of fixed-point frequencies
  localparam int WORD_W = 21;   // packed programming word
  localparam int EDGE_W = 17;   // band edge width in kHz

  typedef enum logic [2:0] {
    S_IDLE, S_MSEL, S_ADD, S_NORM, S_EVAL, S_FIN, S_DIV
  } srch_state_t;

  // VCO band edges in kHz; entry 14 caps band 13
  function automatic logic [EDGE_W-1:0] band_edge(input logic [3:0] i);
    case (i)
      4'd0:    return 17'd50000;
      4'd1:    return 17'd51000;
      4'd2:    return 17'd53200;
      4'd3:    return 17'd58500;
      4'd4:    return 17'd60700;
      4'd5:    return 17'd64400;
      4'd6:    return 17'd66800;
      4'd7:    return 17'd73500;
      4'd8:    return 17'd75600;
      4'd9:    return 17'd80900;
      4'd10:   return 17'd83200;
      4'd11:   return 17'd91500;
      4'd12:   return 17'd100000;
      default: return 17'd120000;
    endcase
  endfunction

  // offset-coded field packing
  function automatic logic [WORD_W-1:0] pack_word(input logic [3:0] idx,
                                                  input logic [9:0] p,
                                                  input logic [2:0] m,
                                                  input logic [6:0] q);
    return {idx, 7'(p - 10'd3), m, 7'(q - 7'd2)};
  endfunction

  function automatic logic [47:0] abs_diff48(input logic [47:0] a,
                                             input logic [47:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/pll_vco_band.sv
`timescale 1ns/1ps
module pll_vco_band
  import pll_search_pkg::*;
#(
  parameter int VKW = 24
) (
  input  logic [VKW-1:0] v,
  output logic [3:0]     idx,
  output logic [17:0]    band_sum
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < 14; i++) begin
      if (v >= VKW'(band_edge(4'(i)))) idx = 4'(i);
    end
    band_sum = 18'(band_edge(idx)) + 18'(band_edge(idx + 4'd1));
  end
endmodule

// File: rtl/pll_freq_divider.sv
`timescale 1ns/1ps
module pll_freq_divider
  import pll_search_pkg::*;
#(
  parameter longint unsigned REF_FX = 64'd1876712489,
  parameter int              FOUT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [7:0]        p_in,
  input  logic [7:0]        q_in,
  input  logic [2:0]        m_in,
  output logic [FOUT_W-1:0] quot,
  output logic              fin
);
  localparam int CW = $clog2(FOUT_W + 1);

  logic [63:0]   rem_r, sh_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic          fits;

  assign fits = rem_r >= sh_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_r <= '0;
      sh_r  <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      quot  <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_r <= REF_FX * 64'(p_in);
        sh_r  <= (64'(q_in) << (5'(m_in) + 5'(FRAC))) << (FOUT_W - 1);
        cnt   <= CW'(FOUT_W);
        run   <= 1'b1;
        quot  <= '0;
      end else if (run) begin
        if (fits) rem_r <= rem_r - sh_r;
        quot <= {quot[FOUT_W-2:0], fits};
        sh_r <= sh_r >> 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // R7: partial remainder stays below twice the current trial divisor
  p_rem_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem_r < (sh_r << 1)));
endmodule

// File: rtl/pll_search_engine.sv
`timescale 1ns/1ps
module pll_search_engine
  import pll_search_pkg::*;
#(
  parameter int              REQ_W       = 20,
  parameter longint unsigned REF_FX      = 64'd1876712489,
  parameter int              F_MIN_KHZ   = 7000,
  parameter int              F_MAX_KHZ   = 120000,
  parameter int              VCO_MIN_KHZ = 50000,
  parameter int              VCO_MAX_KHZ = 120000,
  parameter int              Q_MIN       = 14,
  parameter int              Q_MAX       = 71,
  parameter int              P_MIN       = 4,
  parameter int              P_MAX       = 130,
  parameter int              M_MAX       = 7,
  parameter int              FOUT_W      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_decode,
  input  logic [REQ_W-1:0]  req_khz,
  input  logic [WORD_W-1:0] word_in,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word_out,
  output logic [FOUT_W-1:0] freq_khz,
  output logic              no_match
);
  localparam int KW  = $clog2(F_MAX_KHZ + 1);
  localparam int MW  = $clog2(M_MAX + 1);
  localparam int VKW = KW + M_MAX;
  localparam int QW  = $clog2(Q_MAX + 1);
  localparam int PW  = $clog2(P_MAX + 1) + 2;
  localparam int AW  = 48;
  localparam logic [AW-1:0] REF_A = AW'(REF_FX);
  localparam logic [AW-1:0] REF2  = REF_A << 1;

  srch_state_t st;
  logic [KW-1:0]  f_r;
  logic [MW-1:0]  m_r;
  logic [QW-1:0]  q_r;
  logic [PW-1:0]  p_r;
  logic [AW-1:0]  r2;       // 2*V*q + REF - 2*P*REF, kept in [0, 2*REF)
  logic           op_r;
  logic           have;
  logic [AW-1:0]  b_n2;
  logic [QW-1:0]  b_q;
  logic [PW-1:0]  b_p;
  logic [MW-1:0]  b_m;
  logic [3:0]     b_idx;
  logic [31:0]    b_d;
  logic [VKW-1:0] b_v;
  logic [WORD_W-1:0] word_r;
  logic [FOUT_W-1:0] freq_r;
  logic           nm_r;

  // ---- named internal events ----
  logic [KW-1:0]  req_c;
  logic [VKW-1:0] vkhz;
  logic           in_win;
  logic [AW-1:0]  vfx;
  logic [AW-1:0]  n2;
  logic [3:0]     cur_idx;
  logic [17:0]    cur_sum;
  logic [31:0]    two_v, d_new;
  logic [63:0]    e_new, e_best;
  logic           err_le, err_lt, dev_lt;
  logic           cand_ok, cand_take;
  logic           norm_over, last_m;

  always_comb begin
    if (req_khz < REQ_W'(F_MIN_KHZ))      req_c = KW'(F_MIN_KHZ);
    else if (req_khz > REQ_W'(F_MAX_KHZ)) req_c = KW'(F_MAX_KHZ);
    else                                  req_c = req_khz[KW-1:0];
  end

  assign vkhz      = VKW'(f_r) << m_r;
  assign in_win    = (vkhz >= VKW'(VCO_MIN_KHZ)) && (vkhz <= VKW'(VCO_MAX_KHZ));
  assign vfx       = AW'(vkhz) << FRAC;
  assign n2        = abs_diff48(r2, REF_A);
  assign two_v     = 32'(vkhz) << 1;
  assign d_new     = (two_v > 32'(cur_sum)) ? (two_v - 32'(cur_sum)) : (32'(cur_sum) - two_v);
  assign e_new     = 64'(n2) * 64'(b_q);
  assign e_best    = 64'(b_n2) * 64'(q_r);
  assign err_le    = e_new <= e_best;
  assign err_lt    = e_new <  e_best;
  assign dev_lt    = (64'(d_new) * 64'(b_v)) < (64'(b_d) * 64'(vkhz));
  assign cand_ok   = (st == S_EVAL) && (p_r >= PW'(P_MIN)) && (p_r <= PW'(P_MAX));
  assign cand_take = cand_ok && (!have || (err_le && (err_lt || dev_lt)));
  assign norm_over = r2 >= REF2;
  assign last_m    = m_r == MW'(M_MAX);

  pll_vco_band #(.VKW(VKW)) u_band (
    .v        (vkhz),
    .idx      (cur_idx),
    .band_sum (cur_sum)
  );

  logic              div_go, div_fin;
  logic [7:0]        div_p, div_q;
  logic [2:0]        div_m;
  logic [FOUT_W-1:0] div_quot;

  assign div_go = ((st == S_IDLE) && start && op_decode) || ((st == S_FIN) && have);
  assign div_p  = (st == S_IDLE) ? (8'(word_in[16:10]) + 8'd3) : 8'(b_p);
  assign div_q  = (st == S_IDLE) ? (8'(word_in[6:0]) + 8'd2)   : 8'(b_q);
  assign div_m  = (st == S_IDLE) ? word_in[9:7] : 3'(b_m);

  pll_freq_divider #(.REF_FX(REF_FX), .FOUT_W(FOUT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .p_in  (div_p),
    .q_in  (div_q),
    .m_in  (div_m),
    .quot  (div_quot),
    .fin   (div_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      f_r <= '0; m_r <= '0; q_r <= '0; p_r <= '0; r2 <= '0;
      op_r <= 1'b0; have <= 1'b0;
      b_n2 <= '0; b_q <= '0; b_p <= '0; b_m <= '0; b_idx <= '0; b_d <= '0; b_v <= '0;
      word_r <= '0; freq_r <= '0; nm_r <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_r <= op_decode;
          if (op_decode) begin
            word_r <= word_in;
            st     <= S_DIV;
          end else begin
            f_r  <= req_c;
            m_r  <= '0;
            have <= 1'b0;
            st   <= S_MSEL;
          end
        end
        S_MSEL: begin
          if (in_win) begin
            q_r <= '0;
            p_r <= '0;
            r2  <= REF_A;
            st  <= S_ADD;
          end else if (last_m) st <= S_FIN;
          else m_r <= m_r + 1'b1;
        end
        S_ADD: begin
          r2  <= r2 + (vfx << 1);
          q_r <= q_r + 1'b1;
          st  <= S_NORM;
        end
        S_NORM: begin
          if (norm_over) begin
            r2  <= r2 - REF2;
            p_r <= p_r + 1'b1;
          end else if (q_r < QW'(Q_MIN)) st <= S_ADD;
          else st <= S_EVAL;
        end
        S_EVAL: begin
          if (cand_take) begin
            have  <= 1'b1;
            b_n2  <= n2;
            b_q   <= q_r;
            b_p   <= p_r;
            b_m   <= m_r;
            b_idx <= cur_idx;
            b_d   <= d_new;
            b_v   <= vkhz;
          end
          if (q_r == QW'(Q_MAX)) begin
            if (last_m) st <= S_FIN;
            else begin
              m_r <= m_r + 1'b1;
              st  <= S_MSEL;
            end
          end else st <= S_ADD;
        end
        S_FIN: begin
          if (have) begin
            word_r <= pack_word(b_idx, 10'(b_p), 3'(b_m), 7'(b_q));
            st     <= S_DIV;
          end else begin
            word_r <= '0;
            freq_r <= '0;
            nm_r   <= 1'b1;
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_DIV: if (div_fin) begin
          freq_r <= div_quot;
          nm_r   <= 1'b0;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = st != S_IDLE;
  assign word_out = word_r;
  assign freq_khz = freq_r;
  assign no_match = nm_r;

  // ---- assertions ----
  logic [VKW-1:0] done_vco;
  logic           srch_done;
  assign done_vco  = VKW'(f_r) << word_out[9:7];
  assign srch_done = done && !op_r && !no_match;

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_clamp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_r) |-> (f_r >= KW'(F_MIN_KHZ) && f_r <= KW'(F_MAX_KHZ)));
  p_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (word_out[6:0] >= 7'(Q_MIN - 2) && word_out[6:0] <= 7'(Q_MAX - 2) &&
                   word_out[16:10] >= 7'(P_MIN - 3) && word_out[16:10] <= 7'(P_MAX - 3)));
  p_vco_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (done_vco >= VKW'(VCO_MIN_KHZ) && done_vco <= VKW'(VCO_MAX_KHZ)));
  p_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (done_vco >= VKW'(band_edge(word_out[20:17])) &&
                   (word_out[20:17] == 4'd13 ||
                    done_vco < VKW'(band_edge(word_out[20:17] + 4'd1)))));
  p_nomatch_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (word_out == '0 && freq_khz == '0));
endmodule

// File: tb/pll_search_engine_bench.sv
`timescale 1ns/1ps
module pll_search_engine_bench;
  localparam longint REF = 64'd1876712489;
  localparam int NV = 16;
  localparam int REQS [NV] = '{7000, 25175, 28322, 31500, 36000, 40000, 44900, 50000,
                               57272, 65000, 75000, 80000, 100000, 108000, 119999, 120000};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_decode = 1'b0;
  logic [19:0] req_khz = '0;
  logic [20:0] word_in = '0;
  logic        busy, done, no_match;
  logic [20:0] word_out;
  logic [23:0] freq_khz;

  int n_chk = 0;
  int n_bad = 0;

  pll_search_engine u_pll_search_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_decode(op_decode),
    .req_khz(req_khz), .word_in(word_in), .busy(busy), .done(done),
    .word_out(word_out), .freq_khz(freq_khz), .no_match(no_match)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint edge_of(input int i);
    case (i)
      0: return 50000;   1: return 51000;   2: return 53200;  3: return 58500;
      4: return 60700;   5: return 64400;   6: return 66800;  7: return 73500;
      8: return 75600;   9: return 80900;  10: return 83200; 11: return 91500;
      12: return 100000; default: return 120000;
    endcase
  endfunction

  function automatic int band_of(input longint v);
    for (int i = 13; i >= 0; i--) if (v >= edge_of(i)) return i;
    return 0;
  endfunction

  function automatic longint clamp_of(input longint r);
    if (r < 7000) return 7000;
    if (r > 120000) return 120000;
    return r;
  endfunction

  function automatic longint dec_model(input longint w);
    longint p, q, m;
    q = (w % 128) + 2;
    m = (w / 128) % 8;
    p = ((w / 1024) % 128) + 3;
    return (REF * p) / (q * (64'd1 << (m + 16)));
  endfunction

  function automatic longint search_model(input longint req);
    longint f, bn, bq, bp, bm, bi, bd, bv;
    bit found;
    f = clamp_of(req);
    found = 0; bn = 0; bq = 0; bp = 0; bm = 0; bi = 0; bd = 0; bv = 0;
    for (int m = 0; m < 8; m++) begin
      longint v, vf;
      v = f << m;
      vf = v * 65536;
      if (v < 50000 || v > 120000) continue;
      for (int q = 14; q <= 71; q++) begin
        longint p, n, d, s;
        int b;
        p = (2 * vf * q + REF) / (2 * REF);
        if (p < 4 || p > 130) continue;
        n = p * REF - vf * q;
        if (n < 0) n = -n;
        b = band_of(v);
        s = edge_of(b) + edge_of(b + 1);
        d = 2 * v - s;
        if (d < 0) d = -d;
        if (!found || (n * bq <= bn * q && (n * bq < bn * q || d * bv < bd * v))) begin
          found = 1; bn = n; bq = q; bp = p; bm = m; bi = b; bd = d; bv = v;
        end
      end
    end
    if (!found) return 0;
    return bi * 131072 + (bp - 3) * 1024 + bm * 128 + (bq - 2);
  endfunction

  task automatic run_op(input bit op, input longint req, input longint w, output bit busy_seen);
    @(negedge clk);
    start = 1'b1; op_decode = op; req_khz = 20'(req); word_in = 21'(w);
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    while (!done) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    bit bs;
    longint w7k, w120k, wA, held;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && no_match == 0, "R10 flags in reset", {busy, done, no_match}, 0);
    chk(word_out == 0, "R10 word in reset", word_out, 0);
    chk(freq_khz == 0, "R10 freq in reset", freq_khz, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R6 R8 R11
    for (int k = 0; k < NV; k++) begin
      longint exp_w, vco;
      run_op(1'b0, REQS[k], 0, bs);
      exp_w = search_model(REQS[k]);
      chk(bs == 1, "R9 busy after start", bs, 1);
      chk(word_out == exp_w, "R4/R6 word", word_out, exp_w);
      chk(freq_khz == dec_model(word_out), "R8 achieved freq", freq_khz, dec_model(word_out));
      chk(no_match == 0, "R11 match exists", no_match, 0);
      chk(word_out[6:0] >= 12 && word_out[6:0] <= 69 && word_out[16:10] >= 1 && word_out[16:10] <= 127,
          "R3 P/Q range", word_out, exp_w);
      vco = clamp_of(REQS[k]) << word_out[9:7];
      chk(vco >= 50000 && vco <= 120000, "R2 vco window", vco, 50000);
      chk(word_out[20:17] == band_of(vco), "R5 band index", word_out[20:17], band_of(vco));
      @(negedge clk);
      chk(done == 0, "R9 done single pulse", done, 0);
    end

    // R1: clamping at both ends
    run_op(1'b0, 7000, 0, bs);    w7k = word_out;
    run_op(1'b0, 1000, 0, bs);
    chk(word_out == w7k, "R1 low clamp 1000", word_out, w7k);
    run_op(1'b0, 0, 0, bs);
    chk(word_out == w7k, "R1 low clamp 0", word_out, w7k);
    run_op(1'b0, 120000, 0, bs);  w120k = word_out;
    run_op(1'b0, 500000, 0, bs);
    chk(word_out == w120k, "R1 high clamp", word_out, w120k);

    // R9: start while busy is ignored
    @(negedge clk);
    start = 1'b1; op_decode = 1'b0; req_khz = 20'd40000;
    @(negedge clk);
    req_khz = 20'd90000;   // second start during busy
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    wA = search_model(40000);
    chk(word_out == wA, "R9 start ignored while busy", word_out, wA);
    held = word_out;
    repeat (5) @(negedge clk);
    chk(word_out == held && busy == 0, "R9 outputs hold", word_out, held);

    // R7: decode of known words
    run_op(1'b1, 0, 17426, bs);
    chk(freq_khz == 28636, "R7 decode P=Q m=0", freq_khz, 28636);
    chk(no_match == 0 && word_out == 17426, "R7 decode flags", word_out, 17426);
    run_op(1'b1, 0, 17554, bs);
    chk(freq_khz == 14318, "R7 decode m=1", freq_khz, 14318);
    run_op(1'b1, 0, 37906, bs);
    chk(freq_khz == 57272, "R7 decode P=2Q", freq_khz, 57272);
    run_op(1'b1, 0, 693266, bs);
    chk(freq_khz == 57272, "R7 band bits ignored", freq_khz, 57272);
    run_op(1'b1, 0, 18322, bs);
    chk(freq_khz == 223, "R7 decode m=7", freq_khz, 223);

    finish_run();
  end
endmodule